// File: doc/BRIEF.md
# Tone Parameter Update Unpacker

This block refreshes a bank of tone-generator parameter registers from a DMA write port. The fields are all one byte wide. Group A holds four of them: the upper and lower bytes of a 16-bit amplitude, an 8-bit frequency and an 8-bit tone count. Group B holds `N_CTL` one-byte control fields. A per-field enable vector selects which fields a sequence refreshes.

A pulse on the trigger input starts a sequence while the block is idle. The block samples the enables, decides whether one or two DMA beats are needed and picks the transfer width. It then raises a request and waits for a write strobe on each beat. On each strobe it takes the enabled fields from the 32-bit write word, starting at the most significant byte, and writes them into their target registers. Fields whose enables are clear keep their values.

Top module: `upd_unpack`

## Requirements
- R1: After reset, `dma_req` is low, `xfer_bytes` is 0, and all field registers (`amp_q`, `freq_q`, `tcnt_q`, `ctl_q`) are zero.
- R2: Enable bits are `upd_en[3]` amplitude high, `[2]` amplitude low, `[1]` frequency, `[0]` tone count (group A), and `upd_en[4+i]` control field i (group B). A sequence uses one beat when either group's enables are all clear and two beats otherwise. When every enable is clear, a trigger issues no request.
- R3: In a two-beat sequence, the first beat refreshes group A fields and the second beat refreshes group B fields.
- R4: `xfer_bytes` is set at trigger acceptance. Its value is the larger of the two groups' set-enable counts, with a count of 3 reported as 4, so it takes only the values 1, 2 or 4.
- R5: Enabled fields of the active group are packed from the most significant byte downward: the first takes `dma_wdata[31:24]`, the next `[23:16]`, and so on. Group A packs in the order amplitude high, amplitude low, frequency, tone count. Group B packs in the order control 0 upward. A disabled field takes no slot.
- R6: A field whose enable is clear in the sampled enables keeps its previous value across the sequence.
- R7: Field registers change only on a clock edge where `dma_wr` and `dma_req` are both high. A write strobe while idle has no effect.
- R8: A trigger that arrives while a sequence is in progress is ignored. The sampled enables, `xfer_bytes` and the beat plan are unchanged.
- R9: `dma_req` rises in the cycle after an accepted trigger and stays high through a non-final beat's write. It falls in the cycle after the final beat's write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Periodic start pulse for an update sequence |
| upd_en | input | 4+N_CTL | Per-field update enables |
| dma_wr | input | 1 | DMA write strobe, one cycle per beat |
| dma_wdata | input | 32 | DMA write word (staging contents) |
| dma_req | output | 1 | DMA request, high while a beat is pending |
| xfer_bytes | output | 3 | Transfer width in bytes for the current sequence |
| amp_q | output | 16 | Amplitude register |
| freq_q | output | 8 | Frequency register |
| tcnt_q | output | 8 | Tone count register |
| ctl_q | output | 8*N_CTL | Control field registers, field i at bits [8i+7:8i] |

## Verification
The checker assumes the DMA side pulses `dma_wr` for a single cycle per beat, only while `dma_req` is high. It also assumes that the write word already holds the left-aligned payload for the beat being served. The bench drives every beat as a one-cycle strobe after it has seen the request at a falling edge. It deliberately breaks this rule only once, with a strobe while idle, to show that such a write is ignored. Triggers are held for exactly one cycle, and each overlapping trigger is timed to land inside a pending beat.

// File: rtl/upd_pkg.sv
package upd_pkg;
  localparam int BYTE_W = 8;
  localparam int GRP_A_FIELDS = 4;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_A = 2'd1, ST_B = 2'd2} upd_st_e;

  // round a byte count up to the next power of two (0 stays 0)
  function automatic int pow2_up(input int n);
    int p;
    p = 1;
    if (n == 0) return 0;
    while (p < n) p = p * 2;
    return p;
  endfunction
endpackage

// File: rtl/upd_plan.sv
module upd_plan #(
  parameter int N_CTL = 4,
  parameter int BUS_W = 32
) (
  input  logic [upd_pkg::GRP_A_FIELDS-1:0] en_a,
  input  logic [N_CTL-1:0]                 en_b,
  output logic                             has_a,
  output logic                             has_b,
  output logic [$clog2(BUS_W/8):0]         size
);
  localparam int SZ_W = $clog2(BUS_W/8) + 1;

  int na, nb, mx;

  always_comb begin
    na = 0;
    nb = 0;
    for (int i = 0; i < upd_pkg::GRP_A_FIELDS; i++) na += int'(en_a[i]);
    for (int i = 0; i < N_CTL; i++) nb += int'(en_b[i]);
    mx = (na > nb) ? na : nb;
    size  = SZ_W'(upd_pkg::pow2_up(mx));
    has_a = (na != 0);
    has_b = (nb != 0);
  end
endmodule

// File: rtl/upd_scatter.sv
module upd_scatter #(
  parameter int NF    = 4,
  parameter int BUS_W = 32
) (
  input  logic [NF-1:0]       en,
  input  logic [BUS_W-1:0]    data,
  output logic [NF-1:0][7:0]  fb
);
  logic [BUS_W-1:0] sh [NF];
  int rank;

  always_comb begin
    rank = 0;
    for (int k = 0; k < NF; k++) begin
      sh[k] = data << (8 * rank);
      fb[k] = sh[k][BUS_W-1 -: 8];
      if (en[k]) rank++;
    end
  end
endmodule

// File: rtl/upd_unpack.sv
module upd_unpack #(
  parameter int N_CTL = 4,
  parameter int BUS_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      trig,
  input  logic [4+N_CTL-1:0]        upd_en,
  input  logic                      dma_wr,
  input  logic [BUS_W-1:0]          dma_wdata,
  output logic                      dma_req,
  output logic [$clog2(BUS_W/8):0]  xfer_bytes,
  output logic [15:0]               amp_q,
  output logic [7:0]                freq_q,
  output logic [7:0]                tcnt_q,
  output logic [8*N_CTL-1:0]        ctl_q
);
  import upd_pkg::*;
  localparam int EN_W = GRP_A_FIELDS + N_CTL;
  localparam int SZ_W = $clog2(BUS_W/8) + 1;

  upd_st_e          st;
  logic [EN_W-1:0]  en_q;
  logic             has_a, has_b;
  logic [SZ_W-1:0]  size_c;
  logic [3:0]       ord_a_live, ord_a_q;
  logic [3:0][7:0]  fa;
  logic [N_CTL-1:0][7:0] fb;
  logic             wr_ok, need_b;

  // packing order for group A: index 0 = amplitude high
  assign ord_a_live = {upd_en[0], upd_en[1], upd_en[2], upd_en[3]};
  assign ord_a_q    = {en_q[0], en_q[1], en_q[2], en_q[3]};

  upd_plan #(.N_CTL(N_CTL), .BUS_W(BUS_W)) u_plan (
    .en_a  (ord_a_live),
    .en_b  (upd_en[EN_W-1:4]),
    .has_a (has_a),
    .has_b (has_b),
    .size  (size_c)
  );

  upd_scatter #(.NF(4), .BUS_W(BUS_W)) u_scat_a (
    .en (ord_a_q), .data (dma_wdata), .fb (fa)
  );

  upd_scatter #(.NF(N_CTL), .BUS_W(BUS_W)) u_scat_b (
    .en (en_q[EN_W-1:4]), .data (dma_wdata), .fb (fb)
  );

  assign wr_ok  = dma_wr && dma_req;
  assign need_b = |en_q[EN_W-1:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      dma_req    <= 1'b0;
      en_q       <= '0;
      xfer_bytes <= '0;
    end else begin
      case (st)
        ST_IDLE: if (trig && (has_a || has_b)) begin
          en_q       <= upd_en;
          xfer_bytes <= size_c;
          st         <= has_a ? ST_A : ST_B;
          dma_req    <= 1'b1;
        end
        ST_A: if (wr_ok) begin
          st      <= need_b ? ST_B : ST_IDLE;
          dma_req <= need_b;
        end
        ST_B: if (wr_ok) begin
          st      <= ST_IDLE;
          dma_req <= 1'b0;
        end
        default: begin
          st      <= ST_IDLE;
          dma_req <= 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q  <= '0;
      freq_q <= '0;
      tcnt_q <= '0;
      ctl_q  <= '0;
    end else if (wr_ok) begin
      if (st == ST_A) begin
        if (en_q[3]) amp_q[15:8] <= fa[0];
        if (en_q[2]) amp_q[7:0]  <= fa[1];
        if (en_q[1]) freq_q      <= fa[2];
        if (en_q[0]) tcnt_q      <= fa[3];
      end
      if (st == ST_B) begin
        for (int i = 0; i < N_CTL; i++)
          if (en_q[4+i]) ctl_q[8*i +: 8] <= fb[i];
      end
    end
  end
endmodule

// File: rtl/upd_unpack_chk.sv
module upd_unpack_chk #(
  parameter int N_CTL = 4,
  parameter int BUS_W = 32
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     trig,
  input logic                     dma_wr,
  input logic                     dma_req,
  input logic [$clog2(BUS_W/8):0] xfer_bytes,
  input logic [1:0]               st,
  input logic [4+N_CTL-1:0]       en_q,
  input logic [15:0]              amp_q,
  input logic [7:0]               freq_q,
  input logic [7:0]               tcnt_q,
  input logic [8*N_CTL-1:0]       ctl_q
);
  // R4
  xfer_size_chk: assert property (@(posedge clk) disable iff (rst)
    dma_req |-> (xfer_bytes == 1 || xfer_bytes == 2 || xfer_bytes == 4));

  // R7
  idle_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(dma_wr && dma_req) |=> ($stable(amp_q) && $stable(freq_q) && $stable(tcnt_q) && $stable(ctl_q)));

  // R6
  clear_field_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && dma_req && st == 2'd1 && !en_q[1]) |=> $stable(freq_q));

  // R8
  busy_trig_chk: assert property (@(posedge clk) disable iff (rst)
    (st != 2'd0 && trig) |=> ($stable(en_q) && $stable(xfer_bytes)));

  // R3
  two_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && dma_req && st == 2'd1 && (|en_q[4+N_CTL-1:4])) |=> (dma_req && st == 2'd2));

  // R9
  last_beat_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_wr && dma_req && st == 2'd2) |=> !dma_req);
endmodule

bind upd_unpack upd_unpack_chk #(.N_CTL(N_CTL), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .dma_wr(dma_wr), .dma_req(dma_req),
  .xfer_bytes(xfer_bytes), .st(st), .en_q(en_q), .amp_q(amp_q),
  .freq_q(freq_q), .tcnt_q(tcnt_q), .ctl_q(ctl_q)
);

// File: tb/upd_unpack_test.sv
module upd_unpack_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig = 1'b0;
  logic [7:0]  upd_en = '0;
  logic        dma_wr = 1'b0;
  logic [31:0] dma_wdata = '0;
  logic        dma_req;
  logic [2:0]  xfer_bytes;
  logic [15:0] amp_q;
  logic [7:0]  freq_q, tcnt_q;
  logic [31:0] ctl_q;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  upd_unpack uut (
    .clk(clk), .rst(rst), .trig(trig), .upd_en(upd_en), .dma_wr(dma_wr),
    .dma_wdata(dma_wdata), .dma_req(dma_req), .xfer_bytes(xfer_bytes),
    .amp_q(amp_q), .freq_q(freq_q), .tcnt_q(tcnt_q), .ctl_q(ctl_q)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic fire(input logic [7:0] en);
    @(negedge clk); trig = 1'b1; upd_en = en;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic beat(input logic [31:0] d);
    dma_wr = 1'b1; dma_wdata = d;
    @(negedge clk); dma_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req", 32'(dma_req), 0);
    chk("R1 size", 32'(xfer_bytes), 0);
    chk("R1 amp", 32'(amp_q), 0);
    chk("R1 freq/tcnt", {16'h0, freq_q, tcnt_q}, 0);
    chk("R1 ctl", ctl_q, 0);
  endtask

  task automatic t_full_a;
    fire(8'h0F);
    chk("R9 req rise", 32'(dma_req), 1);
    chk("R4 size4", 32'(xfer_bytes), 4);
    beat(32'hAABBCCDD);
    chk("R5 amp", 32'(amp_q), 32'hAABB);
    chk("R5 freq", 32'(freq_q), 32'hCC);
    chk("R5 tcnt", 32'(tcnt_q), 32'hDD);
    chk("R2 one beat", 32'(dma_req), 0);
  endtask

  task automatic t_sparse_a;
    fire(8'h05);
    chk("R4 size2", 32'(xfer_bytes), 2);
    beat(32'h12340000);
    chk("R6 amp hi kept / R5 lo", 32'(amp_q), 32'hAA12);
    chk("R5 tcnt slot2", 32'(tcnt_q), 32'h34);
    chk("R6 freq kept", 32'(freq_q), 32'hCC);
  endtask

  task automatic t_three;
    fire(8'h0E);
    chk("R4 3->4", 32'(xfer_bytes), 4);
    beat(32'h56789A00);
    chk("R5 amp", 32'(amp_q), 32'h5678);
    chk("R5 freq", 32'(freq_q), 32'h9A);
    chk("R6 tcnt kept", 32'(tcnt_q), 32'h34);
  endtask

  task automatic t_b_only;
    fire(8'h20);
    chk("R4 size1", 32'(xfer_bytes), 1);
    chk("R2 req", 32'(dma_req), 1);
    beat(32'h3C000000);
    chk("R5 ctl1", ctl_q, 32'h00003C00);
    chk("R6 group A kept", 32'(amp_q), 32'h5678);
    chk("R2 single beat", 32'(dma_req), 0);
  endtask

  task automatic t_two_beat;
    fire(8'hD2);
    chk("R4 max size", 32'(xfer_bytes), 4);
    beat(32'h11000000);
    chk("R3 beat A freq", 32'(freq_q), 32'h11);
    chk("R3 ctl untouched", ctl_q, 32'h00003C00);
    chk("R9 req held", 32'(dma_req), 1);
    beat(32'h21436500);
    chk("R3 beat B ctl", ctl_q, 32'h65433C21);
    chk("R3 freq after B", 32'(freq_q), 32'h11);
    chk("R9 req drop", 32'(dma_req), 0);
  endtask

  task automatic t_all_clear;
    fire(8'h00);
    chk("R2 none", 32'(dma_req), 0);
    @(negedge clk);
    chk("R2 none later", 32'(dma_req), 0);
  endtask

  task automatic t_idle_write;
    beat(32'hFFFFFFFF);
    chk("R7 amp", 32'(amp_q), 32'h5678);
    chk("R7 ctl", ctl_q, 32'h65433C21);
    chk("R7 freq/tcnt", {16'h0, freq_q, tcnt_q}, 32'h1134);
  endtask

  task automatic t_busy_trig;
    fire(8'h01);
    trig = 1'b1; upd_en = 8'hF0;
    @(negedge clk); trig = 1'b0;
    chk("R8 size kept", 32'(xfer_bytes), 1);
    beat(32'h77000000);
    chk("R8 tcnt", 32'(tcnt_q), 32'h77);
    chk("R8 req drop", 32'(dma_req), 0);
    @(negedge clk);
    chk("R8 no extra beat", 32'(dma_req), 0);
    chk("R8 ctl kept", ctl_q, 32'h65433C21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full_a();
    t_sparse_a();
    t_three();
    t_b_only();
    t_two_beat();
    t_all_clear();
    t_idle_write();
    t_busy_trig();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule